// File: doc/BRIEF.md
# Serial Frame Aligner and Descrambler

This block sits behind the bit-clock recovery stage of a digital stereo sound receiver. It takes the recovered serial bitstream, qualified by a one-cycle bit enable, and finds where each 728-bit frame begins. It does this by looking for the 8-bit frame alignment word at the same place frame after frame. A lock with hysteresis keeps noise and stray copies of the word inside the payload from pulling the aligner off the true boundary.

Once locked, the block strips the scrambling from the 720 bits that follow each alignment word. It XORs them with a 511-bit pseudo-random sequence that restarts at every frame. It presents the clear bits on a serial output with a valid strobe, so that later stages (deinterleaving, sample expansion, or an external access-control unit) can consume them. The first payload bit of every frame is a sequencing flag. Over 16 frames this flag reads 1 for eight frames and then 0 for eight. The block tracks this pattern and reports the frame's place in the 16-frame cycle.

Top module: `nfa_frame_aligner`

## Requirements
- R1: The alignment word is 01001110, with the leftmost bit received first. In search, it is recognised at any bit position once at least 8 bits have arrived since reset. Lock is reached when the word is seen at 728-bit spacing in 3 consecutive frames. `in_lock` rises in the cycle after the last bit of the third word.
- R2: Before lock, one frame whose word is missing at the expected place returns the block to search, and the count of good frames starts again from zero.
- R3: While locked, lock is kept through up to 3 consecutive frames with a missing word, and the payload of those frames is still delivered. Lock is dropped after the last bit of the 4th consecutive missing word. A word that is present clears the run of misses.
- R4: A copy of the alignment word inside the payload, seen while acquiring or locked, changes neither the lock state nor the frame timing.
- R5: Payload bit k of a frame (k = 0..719, following the 8 word bits) is output as the received bit XOR key bit k. The key comes from a 9-bit register s that is set to all ones before k = 0. Key bit k is s[8], and after each payload bit s becomes {s[7:0], s[8]^s[3]}, which is the polynomial x^9+x^4+1. The alignment word bits are never descrambled or output.
- R6: `clear_vld` is high for one cycle, the cycle after each accepted payload bit, and only while locked. `clear_out` carries that bit's descrambled value in the same cycle. `clear_vld` stays low for alignment word bits and whenever the block is not locked.
- R7: In cycles with `serial_en` low, `serial_in` is ignored and no internal state advances.
- R8: `frame_start` pulses together with `clear_vld` for payload bit 0 of every locked frame, and at no other time.
- R9: Payload bit 0 after descrambling is the sequencing flag. It is 1 in cycle frames 0..7 and 0 in frames 8..15. When it matches the value expected for the next frame, `cycle_idx` advances by one and wraps from 15 to 0. Otherwise `cycle_idx` is set to 0 if the flag is 1 and to 8 if it is 0. The first flag after lock is gained is handled the same way. `cycle_idx` holds its new value from the cycle in which `frame_start` is high.
- R10: Reset is synchronous and active low. It clears lock, the outputs, and `cycle_idx` to 0 in the cycle after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| serial_en | input | 1 | One-cycle strobe marking a valid received bit |
| serial_in | input | 1 | Received (scrambled) serial bit |
| clear_out | output | 1 | Descrambled payload bit |
| clear_vld | output | 1 | Strobe qualifying `clear_out` |
| frame_start | output | 1 | Marks payload bit 0 of a locked frame |
| cycle_idx | output | 4 | Position of the current frame in the 16-frame flag cycle |
| in_lock | output | 1 | Frame alignment held |

## Verification
A wrong bit-position counter shows up one frame later, because the expected alignment word is missed and the bench's per-frame lock and valid-count checks change. A corrupted scrambler register spoils the first descrambled payload bit, which is also the sequencing flag, so both the `clear_out` comparison and `cycle_idx` go wrong within the same frame. Errors in the hit or miss counters change the exact frame in which `in_lock` rises or falls. The bench pins that frame down in runs of good and missing words, so such an error shows within one to four frames.

// File: rtl/nfa_pkg.sv
// Shared types for the serial frame aligner.
// Assumes: nothing beyond a 2-bit encoding for the alignment state.
package nfa_pkg;

    // Alignment state: hunting for the word, confirming it, or holding lock.
    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_ACQ    = 2'd1,
        ST_LOCK   = 2'd2
    } align_state_t;

endpackage

// File: rtl/nfa_faw_detect.sv
// Alignment word detector: keeps the last FAW_W accepted bits and flags,
// combinationally, when the incoming bit completes the pattern.
// Assumes: hit is only meaningful while bit_en is high; at least FAW_W
// bits since reset are needed before any hit is reported.
module nfa_faw_detect #(
    parameter int                FAW_W    = 8,
    parameter logic [FAW_W-1:0]  FAW_WORD = 8'b01001110
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic hit
);

    localparam int FILL_W = $clog2(FAW_W);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(FAW_W - 1);

    logic [FAW_W-1:0]  win_q;
    logic [FAW_W-1:0]  win_next;
    logic [FILL_W-1:0] fill_q;

    assign win_next = {win_q[FAW_W-2:0], bit_in};
    assign hit      = (win_next == FAW_WORD) && (fill_q == FILL_FULL);

    // Shift accepted bits into the window and count them until it is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q  <= '0;
            fill_q <= '0;
        end else if (bit_en) begin
            win_q <= win_next;
            if (fill_q != FILL_FULL) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/nfa_lock_ctrl.sv
// Frame lock controller: tracks the bit position inside the frame and runs
// the search / acquire / lock state machine with hit and miss hysteresis.
// Assumes: ACQ_HITS >= 2 and LOSS_MISSES >= 1; faw_hit is valid with bit_en.
module nfa_lock_ctrl
    import nfa_pkg::*;
#(
    parameter int FRAME_BITS  = 728,
    parameter int FAW_W       = 8,
    parameter int ACQ_HITS    = 3,
    parameter int LOSS_MISSES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic faw_hit,
    output logic locked,
    output logic payload_bit,
    output logic c0_slot,
    output logic key_load,
    output logic key_step
);

    localparam int POS_W   = $clog2(FRAME_BITS);
    localparam int CNT_MAX = (ACQ_HITS > LOSS_MISSES) ? ACQ_HITS : LOSS_MISSES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [POS_W-1:0] POS_WORD_END = POS_W'(FAW_W - 1);
    localparam logic [POS_W-1:0] POS_FIRST    = POS_W'(FAW_W);
    localparam logic [POS_W-1:0] POS_LAST     = POS_W'(FRAME_BITS - 1);

    align_state_t      st_q, st_d;
    logic [POS_W-1:0]  pos_q, pos_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              tracking;
    logic              word_end;

    assign tracking    = (st_q != ST_SEARCH);
    assign word_end    = bit_en && tracking && (pos_q == POS_WORD_END);
    assign locked      = (st_q == ST_LOCK);
    assign payload_bit = tracking && (pos_q >= POS_FIRST);
    assign c0_slot     = (pos_q == POS_FIRST);
    assign key_load    = (bit_en && (st_q == ST_SEARCH) && faw_hit) || word_end;
    assign key_step    = bit_en && payload_bit;

    // Next-state logic: position advance and hit/miss hysteresis.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        pos_d = pos_q;
        if (bit_en) begin
            pos_d = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
        end
        case (st_q)
            ST_SEARCH: begin
                if (bit_en && faw_hit) begin
                    pos_d = POS_FIRST;
                    cnt_d = CNT_W'(1);
                    st_d  = ST_ACQ;
                end
            end
            ST_ACQ: begin
                if (word_end) begin
                    if (!faw_hit) begin
                        st_d  = ST_SEARCH;
                        cnt_d = '0;
                    end else if (cnt_q == CNT_W'(ACQ_HITS - 1)) begin
                        st_d  = ST_LOCK;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_LOCK: begin
                if (word_end) begin
                    if (faw_hit) begin
                        cnt_d = '0;
                    end else if (cnt_q == CNT_W'(LOSS_MISSES - 1)) begin
                        st_d  = ST_SEARCH;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                st_d  = ST_SEARCH;
                cnt_d = '0;
            end
        endcase
    end

    // State, position and hysteresis counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_SEARCH;
            pos_q <= '0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            pos_q <= pos_d;
            cnt_q <= cnt_d;
        end
    end

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= POS_LAST);  // R1

    AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(st_q == ST_LOCK)) |-> $past(bit_en && faw_hit));  // R1

    AST_LOCK_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(st_q == ST_LOCK)) |-> $past(bit_en && !faw_hit));  // R3

    AST_MISS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOCK) |-> (cnt_q < CNT_W'(LOSS_MISSES)));  // R3

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bit_en)) |-> ($stable(pos_q) && $stable(st_q)));  // R7

endmodule

// File: rtl/nfa_prbs.sv
// Key sequence generator: a Fibonacci shift register that restarts at all
// ones on load and steps once per payload bit; key_bit is its top bit.
// Assumes: load and step never coincide (load happens on word bits only).
module nfa_prbs #(
    parameter int WIDTH = 9,
    parameter int TAP   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    output logic key_bit
);

    logic [WIDTH-1:0] lfsr_q;
    logic             feedback;

    assign key_bit  = lfsr_q[WIDTH-1];
    assign feedback = lfsr_q[WIDTH-1] ^ lfsr_q[TAP-1];

    // Restart the sequence at each frame or advance it by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= '1;
        end else if (load) begin
            lfsr_q <= '1;
        end else if (step) begin
            lfsr_q <= {lfsr_q[WIDTH-2:0], feedback};
        end
    end

    AST_PRBS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);  // R5

    AST_LOAD_STEP_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step));  // R5

endmodule

// File: rtl/nfa_cycle_track.sv
// Sequencing-flag tracker: follows the 16-frame pattern of the first payload
// bit and resynchronises the index whenever the flag breaks the pattern.
// Assumes: sample is high for exactly one bit per locked frame.
module nfa_cycle_track #(
    parameter int CYCLE_LEN = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         locked,
    input  logic                         sample,
    input  logic                         flag,
    output logic [$clog2(CYCLE_LEN)-1:0] idx
);

    localparam int IDX_W = $clog2(CYCLE_LEN);
    localparam logic [IDX_W-1:0] HALF = IDX_W'(CYCLE_LEN / 2);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(CYCLE_LEN - 1);

    logic             seen_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_inc;
    logic             flag_exp;

    assign idx_inc  = (idx_q == LAST) ? '0 : idx_q + 1'b1;
    assign flag_exp = (idx_inc < HALF);
    assign idx      = idx_q;

    // Advance on a matching flag, otherwise jump to the half the flag implies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            idx_q  <= '0;
        end else if (!locked) begin
            seen_q <= 1'b0;
        end else if (sample) begin
            seen_q <= 1'b1;
            if (seen_q && (flag == flag_exp)) begin
                idx_q <= idx_inc;
            end else begin
                idx_q <= flag ? '0 : HALF;
            end
        end
    end

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sample)) |-> $stable(idx_q));  // R9

    AST_IDX_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sample && locked)) |-> ((idx_q < HALF) == $past(flag)));  // R9

endmodule

// File: rtl/nfa_frame_aligner.sv
// Frame aligner and descrambler top: joins the word detector, lock control,
// key generator and flag tracker, and registers the serial outputs.
// Assumes: one received bit per serial_en strobe; outputs lag by one cycle.
module nfa_frame_aligner #(
    parameter int                FRAME_BITS  = 728,
    parameter int                FAW_W       = 8,
    parameter logic [FAW_W-1:0]  FAW_WORD    = 8'b01001110,
    parameter int                ACQ_HITS    = 3,
    parameter int                LOSS_MISSES = 4,
    parameter int                PRBS_W      = 9,
    parameter int                PRBS_TAP    = 4,
    parameter int                CYCLE_LEN   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         serial_en,
    input  logic                         serial_in,
    output logic                         clear_out,
    output logic                         clear_vld,
    output logic                         frame_start,
    output logic [$clog2(CYCLE_LEN)-1:0] cycle_idx,
    output logic                         in_lock
);

    logic faw_hit;
    logic payload_bit;
    logic c0_slot;
    logic key_load;
    logic key_step;
    logic key_bit;
    logic take;

    nfa_faw_detect #(
        .FAW_W    (FAW_W),
        .FAW_WORD (FAW_WORD)
    ) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (serial_en),
        .bit_in (serial_in),
        .hit    (faw_hit)
    );

    nfa_lock_ctrl #(
        .FRAME_BITS  (FRAME_BITS),
        .FAW_W       (FAW_W),
        .ACQ_HITS    (ACQ_HITS),
        .LOSS_MISSES (LOSS_MISSES)
    ) u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (serial_en),
        .faw_hit     (faw_hit),
        .locked      (in_lock),
        .payload_bit (payload_bit),
        .c0_slot     (c0_slot),
        .key_load    (key_load),
        .key_step    (key_step)
    );

    nfa_prbs #(
        .WIDTH (PRBS_W),
        .TAP   (PRBS_TAP)
    ) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (key_load),
        .step    (key_step),
        .key_bit (key_bit)
    );

    assign take = serial_en && in_lock && payload_bit;

    nfa_cycle_track #(
        .CYCLE_LEN (CYCLE_LEN)
    ) u_cycle (
        .clk    (clk),
        .rst_n  (rst_n),
        .locked (in_lock),
        .sample (take && c0_slot),
        .flag   (serial_in ^ key_bit),
        .idx    (cycle_idx)
    );

    // Register the descrambled bit, its strobe and the frame marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clear_out   <= 1'b0;
            clear_vld   <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            clear_vld   <= take;
            frame_start <= take && c0_slot;
            clear_out   <= take ? (serial_in ^ key_bit) : 1'b0;
        end
    end

    AST_VLD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        clear_vld |-> in_lock);  // R6

    AST_VLD_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
        clear_vld |-> $past(serial_en));  // R7

    AST_FS_IN_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> clear_vld);  // R8

    AST_FS_NOT_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);  // R8

endmodule

// File: tb/nfa_frame_aligner_bench.sv
module nfa_frame_aligner_bench;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME_BITS = 728;
    localparam int PAY_BITS   = 720;
    localparam int ALIAS_AT   = 100;
    localparam logic [7:0] WORD = 8'b01001110;
    localparam int N_VEC = 25;

    // {word_ok, flag, alias, exp_lock, exp_valid, exp_idx[3:0]}
    localparam logic [8:0] VEC [N_VEC] = '{
        9'b1_1_0_0_0_0000,  // F0  first word, search -> acquire
        9'b1_1_1_0_0_0000,  // F1  alias while acquiring
        9'b1_1_0_1_1_0000,  // F2  third word: lock, first flag 1 -> 0
        9'b1_0_0_1_1_1000,  // F3  flag 0 breaks run -> 8
        9'b1_0_0_1_1_1001,  // F4
        9'b1_0_1_1_1_1010,  // F5  alias while locked
        9'b0_0_0_1_1_1011,  // F6  one miss
        9'b1_0_0_1_1_1100,  // F7  word back, misses cleared
        9'b1_1_0_1_1_0000,  // F8  flag break -> 0
        9'b1_1_0_1_1_0001,  // F9
        9'b0_1_0_1_1_0010,  // F10 miss 1
        9'b0_1_0_1_1_0011,  // F11 miss 2
        9'b0_1_0_1_1_0100,  // F12 miss 3, still locked
        9'b0_1_0_0_0_0000,  // F13 miss 4, lock lost
        9'b1_0_0_0_0_0000,  // F14
        9'b1_0_0_0_0_0000,  // F15
        9'b1_0_0_1_1_1000,  // F16 relock, first flag 0 -> 8
        9'b1_0_0_1_1_1001,
        9'b1_0_0_1_1_1010,
        9'b1_0_0_1_1_1011,
        9'b1_0_0_1_1_1100,
        9'b1_0_0_1_1_1101,
        9'b1_0_0_1_1_1110,
        9'b1_0_0_1_1_1111,  // F23 index 15
        9'b1_1_0_1_1_0000   // F24 wrap to 0
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       serial_en;
    logic       serial_in;
    logic       clear_out;
    logic       clear_vld;
    logic       frame_start;
    logic [3:0] cycle_idx;
    logic       in_lock;

    int n_chk = 0;
    int n_bad = 0;
    int f_vld, f_bad, f_fs, f_idx, f_lock;

    always #(CLK_PERIOD / 2) clk = ~clk;

    nfa_frame_aligner u_nfa_frame_aligner (
        .clk         (clk),
        .rst_n       (rst_n),
        .serial_en   (serial_en),
        .serial_in   (serial_in),
        .clear_out   (clear_out),
        .clear_vld   (clear_vld),
        .frame_start (frame_start),
        .cycle_idx   (cycle_idx),
        .in_lock     (in_lock)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One bit: strobe it in, then an idle cycle with the inverted bit (R7).
    task automatic push_bit(input logic b);
        @(negedge clk);
        serial_en = 1'b1;
        serial_in = b;
        @(negedge clk);
        serial_en = 1'b0;
        serial_in = ~b;
    endtask

    task automatic send_frame(input logic word_ok, input logic flag, input logic alias_on);
        logic [8:0] ks;
        logic raw, key, want;
        ks = '1;
        f_vld = 0; f_bad = 0; f_fs = 0; f_idx = -1;
        for (int i = 0; i < FRAME_BITS; i++) begin
            key = 1'b0;
            if (i < 8) begin
                raw = word_ok ? WORD[7-i] : 1'b0;
            end else begin
                key = ks[8];
                ks  = {ks[7:0], ks[8] ^ ks[3]};
                if (i == 8)
                    raw = flag ^ key;
                else if (alias_on && i >= ALIAS_AT && i < ALIAS_AT + 8)
                    raw = WORD[7-(i-ALIAS_AT)];
                else
                    raw = 1'b0;
            end
            want = raw ^ key;
            push_bit(raw);
            if (clear_vld) begin
                f_vld++;
                if (i < 8 || clear_out !== want) f_bad++;
            end
            if (frame_start) begin
                f_fs++;
                f_idx = int'(cycle_idx);
                if (i != 8) f_bad++;
            end
        end
        f_lock = int'(in_lock);
    endtask

    initial begin
        rst_n = 1'b0;
        serial_en = 1'b0;
        serial_in = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 reset in_lock", int'(in_lock), 0);
        check("R10 reset clear_vld", int'(clear_vld), 0);
        check("R10 reset cycle_idx", int'(cycle_idx), 0);
        rst_n = 1'b1;

        for (int v = 0; v < N_VEC; v++) begin
            send_frame(VEC[v][8], VEC[v][7], VEC[v][6]);
            check($sformatf("R1 R3 lock after frame %0d", v), f_lock, int'(VEC[v][5]));
            check($sformatf("R6 valid count frame %0d", v), f_vld, VEC[v][4] ? PAY_BITS : 0);
            check($sformatf("R5 R7 data errors frame %0d", v), f_bad, 0);
            check($sformatf("R8 frame_start count frame %0d", v), f_fs, int'(VEC[v][4]));
            if (VEC[v][4])
                check($sformatf("R9 cycle_idx frame %0d", v), f_idx, int'(VEC[v][3:0]));
            if (VEC[v][6])
                check($sformatf("R4 alias frame %0d lock", v), f_lock, int'(VEC[v][5]));
        end

        // Reset while locked clears everything in one cycle.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset while locked in_lock", int'(in_lock), 0);
        check("R10 reset while locked cycle_idx", int'(cycle_idx), 0);
        check("R10 reset while locked clear_out", int'(clear_out), 0);
        rst_n = 1'b1;

        // A miss during acquisition restarts the count of good frames.
        send_frame(1'b1, 1'b1, 1'b0);
        send_frame(1'b1, 1'b1, 1'b0);
        send_frame(1'b0, 1'b1, 1'b0);
        check("R2 miss in acquisition", f_lock, 0);
        send_frame(1'b1, 1'b1, 1'b0);
        check("R2 one good after restart", f_lock, 0);
        send_frame(1'b1, 1'b1, 1'b0);
        check("R2 two good after restart", f_lock, 0);
        send_frame(1'b1, 1'b1, 1'b0);
        check("R2 three good after restart", f_lock, 1);
        check("R2 R6 payload after relock", f_vld, PAY_BITS);
        check("R2 R9 first flag after relock", f_idx, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule